// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Register

This block holds the eight interrupt flags of a stand-alone CAN controller and drives its active-low interrupt request. The protocol core reports to it through event pulses (bus error, arbitration lost) and status levels: error-passive state, sleep with bus activity, data overrun, error status, bus status, transmit-buffer-released and receive-FIFO-not-empty. Each flag is gated by its own bit of an eight-bit enable byte that comes from elsewhere in the controller.

The CPU sees the flags as a read-only byte. A read strobe clears every flag except the receive flag. The receive flag is not a latch. It follows the FIFO's not-empty level, so it falls only when the FIFO runs dry. Several flags are set by edge or change detection on status levels, and the history registers that do this are cleared by the synchronous reset together with the flags.

Top module: `can_irq_flags`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all flags and all status history registers. After reset, `flags` is 0x00 and `irq_n` is 1.
- R2: Bit 7 sets on an `ev_bus_err` pulse and bit 6 sets on an `ev_arb_lost` pulse. Each takes effect at the next clock edge.
- R3: Bit 5 sets on every change of `st_err_passive`, both entering error passive and returning to error active.
- R4: Bit 4 (wake-up) sets when `sleeping` and `bus_activity` are both high in the same cycle.
- R5: Bit 3 sets only on a 0-to-1 transition of `st_overrun`. A level that stays high does not set it again after it has been cleared.
- R6: Bit 2 sets on any change, rising or falling, of `st_err` or of `st_bus`.
- R7: Bit 1 sets only on a 0-to-1 transition of `st_tx_free`, which marks the transmit buffer as released.
- R8: Bit 0 equals `rx_not_empty & irq_en[0]`, registered one cycle, and a read does not affect it.
- R9: A `cpu_rd` pulse clears bits 7 to 1 at the next clock edge.
- R10: When a set condition and `cpu_rd` fall in the same cycle, the set wins and that flag reads 1 afterwards.
- R11: A flag sets only when its matching `irq_en` bit (same bit position) is 1.
- R12: `cpu_wr` has no effect on the flags.
- R13: `irq_n` is 0 exactly when at least one flag bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_rd | input | 1 | CPU read strobe for the flag byte |
| cpu_wr | input | 1 | CPU write strobe to the flag byte, ignored |
| irq_en | input | 8 | Per-flag enable, same bit order as `flags` |
| ev_bus_err | input | 1 | Bus error event pulse |
| ev_arb_lost | input | 1 | Arbitration lost event pulse |
| st_err_passive | input | 1 | Error-passive state level |
| sleeping | input | 1 | Controller is in sleep mode |
| bus_activity | input | 1 | Bus activity seen |
| st_overrun | input | 1 | Data overrun status level |
| st_err | input | 1 | Error status level |
| st_bus | input | 1 | Bus status level |
| st_tx_free | input | 1 | Transmit buffer released status |
| rx_not_empty | input | 1 | Receive FIFO holds at least one message |
| flags | output | 8 | Flag byte: 7 bus error, 6 arbitration lost, 5 error passive, 4 wake-up, 3 overrun, 2 error warning, 1 transmit, 0 receive |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The CPU read-clear and a new set condition can fall in the same cycle. A lost event there would go unnoticed by software. The bench provokes this by raising the overrun status, or toggling the bus status or error status, in the very cycle that carries `cpu_rd`. It then expects the new flag to read 1 while the other latched flags read 0. A read with a status level held high must clear the flag and leave it clear, which separates edge detection from level sensing.

// File: rtl/can_irq_flags.sv
module can_irq_flags (
  input  logic       clk,
  input  logic       rst,
  input  logic       cpu_rd,
  input  logic       cpu_wr,
  input  logic [7:0] irq_en,
  input  logic       ev_bus_err,
  input  logic       ev_arb_lost,
  input  logic       st_err_passive,
  input  logic       sleeping,
  input  logic       bus_activity,
  input  logic       st_overrun,
  input  logic       st_err,
  input  logic       st_bus,
  input  logic       st_tx_free,
  input  logic       rx_not_empty,
  output logic [7:0] flags,
  output logic       irq_n
);

  logic [7:1] flg_q;
  logic       rx_q;
  logic       ep_h, ovr_h, err_h, bus_h, tx_h;
  logic [7:1] set_v;

  assign set_v[7] = ev_bus_err  & irq_en[7];
  assign set_v[6] = ev_arb_lost & irq_en[6];
  assign set_v[5] = (st_err_passive ^ ep_h) & irq_en[5];
  assign set_v[4] = sleeping & bus_activity & irq_en[4];
  assign set_v[3] = st_overrun & ~ovr_h & irq_en[3];
  assign set_v[2] = ((st_err ^ err_h) | (st_bus ^ bus_h)) & irq_en[2];
  assign set_v[1] = st_tx_free & ~tx_h & irq_en[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ep_h  <= 1'b0;
      ovr_h <= 1'b0;
      err_h <= 1'b0;
      bus_h <= 1'b0;
      tx_h  <= 1'b0;
    end else begin
      ep_h  <= st_err_passive;
      ovr_h <= st_overrun;
      err_h <= st_err;
      bus_h <= st_bus;
      tx_h  <= st_tx_free;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q <= '0;
      rx_q  <= 1'b0;
    end else begin
      flg_q <= set_v | (flg_q & {7{~cpu_rd}});
      rx_q  <= rx_not_empty & irq_en[0];
    end
  end

  assign flags = {flg_q, rx_q};
  assign irq_n = ~|flags;

  assert_read_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && set_v == 7'd0) |=> flags[7:1] == 7'd0);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && set_v != 7'd0) |=> ((flags[7:1] & $past(set_v)) == $past(set_v)));

  assert_write_ignored_R12: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !cpu_rd && set_v == 7'd0) |=> $stable(flags[7:1]));

  assert_enable_gate_R11: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && irq_en[7:1] == 7'd0) |=> flags[7:1] == 7'd0);

  assert_rx_level_R8: assert property (@(posedge clk) disable iff (rst)
    (!rx_not_empty) |=> !flags[0]);

endmodule

// File: tb/test_can_irq_flags.sv
module test_can_irq_flags;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_rd = 0, cpu_wr = 0;
  logic [7:0] irq_en = 8'hFF;
  logic       ev_bus_err = 0, ev_arb_lost = 0, st_err_passive = 0, sleeping = 0;
  logic       bus_activity = 0, st_overrun = 0, st_err = 0, st_bus = 0;
  logic       st_tx_free = 0, rx_not_empty = 0;
  logic [7:0] flags;
  logic       irq_n;

  int checks = 0, errors = 0;
  logic [7:0] m_flags = 8'h00;
  logic m_ep = 0, m_ovr = 0, m_err = 0, m_bus = 0, m_tx = 0;

  always #5 clk = ~clk;

  can_irq_flags i_can_irq_flags (
    .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .irq_en(irq_en),
    .ev_bus_err(ev_bus_err), .ev_arb_lost(ev_arb_lost), .st_err_passive(st_err_passive),
    .sleeping(sleeping), .bus_activity(bus_activity), .st_overrun(st_overrun),
    .st_err(st_err), .st_bus(st_bus), .st_tx_free(st_tx_free),
    .rx_not_empty(rx_not_empty), .flags(flags), .irq_n(irq_n));

  // bits: rd wr be al ep sleep act ovr err bus tx rxne | en[7:0]
  localparam int N = 20;
  localparam logic [19:0] VEC [N] = '{
    {12'b000000000000, 8'hFF},
    {12'b001000000000, 8'hFF},
    {12'b100000000000, 8'hFF},
    {12'b000100000000, 8'hFF},
    {12'b000010000000, 8'hFF},
    {12'b100010000000, 8'hFF},
    {12'b000000000000, 8'hFF},
    {12'b000001100000, 8'hFF},
    {12'b100000010000, 8'hFF},
    {12'b100000010000, 8'hFF},
    {12'b000000011000, 8'hFF},
    {12'b100000011100, 8'hFF},
    {12'b100000010100, 8'hFF},
    {12'b100000010100, 8'hFF},
    {12'b000000010111, 8'hFF},
    {12'b100000010111, 8'hFF},
    {12'b000000010111, 8'hFE},
    {12'b001000010111, 8'hFF},
    {12'b010000010111, 8'hFF},
    {12'b101100000011, 8'h00}
  };

  function automatic string row_req(int i);
    case (i)
      0: return "R13";  1: return "R2";   2: return "R9";   3: return "R2";
      4: return "R3";   5: return "R9";   6: return "R3";   7: return "R4";
      8: return "R10";  9: return "R5";  10: return "R6";  11: return "R6";
      12: return "R6"; 13: return "R9";  14: return "R7";  15: return "R8";
      16: return "R8"; 17: return "R2";  18: return "R12"; default: return "R11";
    endcase
  endfunction

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: flags/irq_n actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [19:0] v);
    logic [7:1] s;
    logic [7:0] en;
    logic rd;
    @(negedge clk);
    {cpu_rd, cpu_wr, ev_bus_err, ev_arb_lost, st_err_passive, sleeping, bus_activity,
     st_overrun, st_err, st_bus, st_tx_free, rx_not_empty, irq_en} = v;
    en = v[7:0];
    rd = v[19];
    s[7] = v[17] & en[7];
    s[6] = v[16] & en[6];
    s[5] = (v[15] ^ m_ep) & en[5];
    s[4] = v[14] & v[13] & en[4];
    s[3] = v[12] & ~m_ovr & en[3];
    s[2] = ((v[11] ^ m_err) | (v[10] ^ m_bus)) & en[2];
    s[1] = v[9] & ~m_tx & en[1];
    m_flags[7:1] = s | (m_flags[7:1] & {7{~rd}});
    m_flags[0] = v[8] & en[0];
    m_ep = v[15]; m_ovr = v[12]; m_err = v[11]; m_bus = v[10]; m_tx = v[9];
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    {cpu_rd, cpu_wr, ev_bus_err, ev_arb_lost, st_err_passive, sleeping, bus_activity,
     st_overrun, st_err, st_bus, st_tx_free, rx_not_empty} = '0;
    irq_en = 8'hFF;
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    m_flags = 0; m_ep = 0; m_ovr = 0; m_err = 0; m_bus = 0; m_tx = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check("R1", {flags, irq_n}, {8'h00, 1'b1});

    for (int i = 0; i < N; i++) begin
      apply(VEC[i]);
      check(row_req(i), {flags, irq_n}, {m_flags, ~|m_flags});
    end

    // R1: reset mid-run with flags set and history high
    apply({12'b001000010110, 8'hFF});
    do_reset();
    check("R1", {flags, irq_n}, {8'h00, 1'b1});

    // R10: overrun rises in the cycle of a read; bus error latched before
    apply({12'b001000000000, 8'hFF});
    apply({12'b100000010000, 8'hFF});
    check("R10", {flags, irq_n}, {8'h08, 1'b0});

    // R5: level held high after a read does not re-set
    apply({12'b100000010000, 8'hFF});
    apply({12'b000000010000, 8'hFF});
    check("R5", {flags, irq_n}, {8'h00, 1'b1});

    // R7: released after a reset with history 0 -> set; held -> none after read
    apply({12'b000000000010, 8'hFF});
    check("R7", {flags, irq_n}, {8'h02, 1'b0});
    apply({12'b100000000010, 8'hFF});
    check("R7", {flags, irq_n}, {8'h00, 1'b1});

    // R13: receive flag alone pulls the request low
    apply({12'b000000000011, 8'h01});
    check("R13", {flags, irq_n}, {8'h01, 1'b0});

    // R11: wake-up with its enable off
    apply({12'b000001100011, 8'hEF});
    check("R11", {flags, irq_n}, {8'h01, 1'b0});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule